// File: doc/BRIEF.md
# Set-Associative Tag Directory with Run-Time Replacement Choice

This block holds only the tags of a set-associative cache. Each request carries an address. The block splits the address into a tag, a set index and a byte offset. It then looks the tag up among the ways of the indexed set. A response follows one clock later. The response gives hit or miss, the way that was hit or filled, and the victim way that the replacement logic chose.

On a miss, the directory writes the new tag into the victim way at the same clock edge that registers the response. Any later request to that line then hits. The victim is chosen by one of three policies, selected at run time:

- first-in-first-out;
- exact least-recently-used, kept as an age rank per way;
- a reference-bit approximation, with one bit per line that any access sets and that a periodic pulse clears everywhere.

A 32-bit counter of missed requests is exposed for measurement. The counter can be cleared.

Top module: `repl_tag_directory`

## Requirements
- R1: With the default 32-bit address, 32-byte lines, 4 ways and 16 KB capacity (128 sets), the address splits as follows: bits [4:0] are the offset, which is ignored by the lookup; bits [11:5] are the set index; bits [31:12] are the tag. A 2-way build with 128 sets uses the same split.
- R2: A request hits only when a way of its indexed set is valid and holds the same tag. Reset marks every way invalid, so an all-zero address misses after reset.
- R3: While a set has an invalid way, a miss fills the lowest-numbered invalid way, whatever policy is selected.
- R4: A miss writes its tag into the victim way at the response edge. The reported way then equals the reported victim, and the next request to the same line hits in that way.
- R5: With policySel = 0 (FIFO), the evicted valid way is the one filled earliest, and hits leave that order unchanged. In a 2-way single-set trace A B C A B C B A B D from empty, this gives 9 misses, and only the seventh access hits.
- R6: With policySel = 1 (LRU; the value 3 behaves the same), the evicted valid way is the one accessed least recently, and hits refresh recency. The same trace gives 8 misses, with hits on the seventh and ninth accesses.
- R7: With policySel = 2 (reference bits), any access sets its line's bit, and a refClear pulse clears every bit. The victim among valid ways is the lowest-numbered way whose bit is 0, or way 0 when all bits are 1.
- R8: A change of policySel, made while no request is active, resets the ordering. Way n receives rank n, so the highest-numbered valid way is the next to be evicted. The change also clears every reference bit. Tags and valid bits are kept.
- R9: missCount rises by exactly one per missed request and holds on hits. A missClr clears it to 0, and the clear wins over a miss in the same cycle. Reset sets it to 0.
- R10: rspValid is high in the cycle after each cycle with reqValid high, and low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policySel | input | 2 | 0 FIFO, 1 or 3 LRU, 2 reference bits |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | ADDR_W | Request address |
| refClear | input | 1 | Pulse that clears all reference bits |
| missClr | input | 1 | Clears the miss counter |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspHit | output | 1 | Request hit |
| rspWay | output | WAY_W | Way hit, or way filled on a miss |
| rspVictim | output | WAY_W | Victim way chosen for the request's set |
| missCount | output | 32 | Number of missed requests |

## Verification
The hardest states to reach from the ports are those in which the ordering state disagrees with the fill order. Three such cases are stressed:

- A full set under reference bits, where every bit is set. Two fills into a 2-way set put the set there, and clear pulses placed between accesses then move the victim to a chosen way.
- A policy switch while the LRU ranks are not in identity order. It is reached by filling two ways, changing policySel while idle, and checking that the next miss evicts way 1 rather than way 0.
- A counter clear that coincides with a miss.

Two known single-set traces fix the FIFO and LRU miss totals.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    POL_FIFO = 2'd0,
    POL_LRU  = 2'd1,
    POL_REF  = 2'd2,
    POL_ALT  = 2'd3
  } policy_e;

  typedef struct packed {
    logic install;     // write tag into victim way
    logic promote;     // move touched way to rank 0
    logic markRef;     // set reference bit of touched way
    logic orderReset;  // ranks back to identity
    logic refReset;    // clear all reference bits
    logic refPick;     // choose victim from reference bits
  } dirStrobe_t;

endpackage

// File: rtl/tagdir_ctrl.sv
module tagdir_ctrl
  import tagdir_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       policySel,
  input  logic             reqValid,
  input  logic             lookupHit,
  input  logic             refClear,
  input  logic             missClr,
  output dirStrobe_t       strobe,
  output logic [CNT_W-1:0] missCount
);

  policy_e policyNow;
  policy_e policyQ;
  logic    isLru;
  logic    isRef;

  assign policyNow = policy_e'(policySel);
  assign isLru     = (policyNow == POL_LRU) || (policyNow == POL_ALT);
  assign isRef     = (policyNow == POL_REF);

  always_ff @(posedge clk) begin
    if (rst) policyQ <= POL_FIFO;
    else     policyQ <= policyNow;
  end

  always_comb begin
    strobe.install    = reqValid && !lookupHit;
    // LRU ranks move on every access, FIFO ranks only on a fill
    strobe.promote    = reqValid && (isLru || (!isRef && !lookupHit));
    strobe.markRef    = reqValid;
    strobe.orderReset = (policyNow != policyQ);
    strobe.refReset   = refClear || (policyNow != policyQ);
    strobe.refPick    = isRef;
  end

  always_ff @(posedge clk) begin
    if (rst || missClr)      missCount <= '0;
    else if (strobe.install) missCount <= missCount + CNT_W'(1);
  end

endmodule

// File: rtl/tagdir_path.sv
module tagdir_path
  import tagdir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SET_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  dirStrobe_t        strobe,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              lookupHit,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic [WAY_W-1:0]  rspVictim
);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [WAYS-1:0]  refMem   [SETS];
  logic [WAY_W-1:0] rankMem  [SETS][WAYS];

  logic [TAG_W-1:0] reqTag;
  logic [SET_W-1:0] reqSet;
  logic             unusedOffset;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay;
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] touchWay;
  logic [WAY_W-1:0] touchRank;

  assign reqTag       = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSet       = reqAddr[OFF_W +: SET_W];
  assign unusedOffset = ^reqAddr[OFF_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validMem[reqSet][w] && (tagMem[reqSet][w] == reqTag);
  end

  assign lookupHit = |hitVec;

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    logic gotFree;
    logic gotRef;
    victim  = '0;
    gotFree = 1'b0;
    gotRef  = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!gotFree && !validMem[reqSet][w]) begin
        victim  = WAY_W'(w);
        gotFree = 1'b1;
      end
    if (!gotFree) begin
      if (strobe.refPick) begin
        for (int w = 0; w < WAYS; w++)
          if (!gotRef && !refMem[reqSet][w]) begin
            victim = WAY_W'(w);
            gotRef = 1'b1;
          end
      end else begin
        for (int w = 0; w < WAYS; w++)
          if (rankMem[reqSet][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end

  assign touchWay  = lookupHit ? hitWay : victim;
  assign touchRank = rankMem[reqSet][touchWay];

  always_ff @(posedge clk) begin
    if (strobe.install) tagMem[reqSet][victim] <= reqTag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspWay    <= '0;
      rspVictim <= '0;
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        refMem[s]   <= '0;
        for (int w = 0; w < WAYS; w++) rankMem[s][w] <= WAY_W'(w);
      end
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspHit    <= lookupHit;
        rspWay    <= touchWay;
        rspVictim <= victim;
      end
      if (strobe.install) validMem[reqSet][victim] <= 1'b1;
      if (strobe.orderReset) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) rankMem[s][w] <= WAY_W'(w);
      end else if (strobe.promote) begin
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == touchWay)
            rankMem[reqSet][w] <= '0;
          else if (rankMem[reqSet][w] < touchRank)
            rankMem[reqSet][w] <= rankMem[reqSet][w] + WAY_W'(1);
      end
      if (strobe.refReset)
        for (int s = 0; s < SETS; s++) refMem[s] <= '0;
      if (strobe.markRef) refMem[reqSet][touchWay] <= 1'b1;
    end
  end

endmodule

// File: rtl/repl_tag_directory.sv
module repl_tag_directory
  import tagdir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        policySel,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              refClear,
  input  logic              missClr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic [WAY_W-1:0]  rspVictim,
  output logic [31:0]       missCount
);

  dirStrobe_t strobe;
  logic       lookupHit;

  tagdir_ctrl #(.CNT_W(32)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .policySel (policySel),
    .reqValid  (reqValid),
    .lookupHit (lookupHit),
    .refClear  (refClear),
    .missClr   (missClr),
    .strobe    (strobe),
    .missCount (missCount)
  );

  tagdir_path #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .WAYS       (WAYS),
    .SETS       (SETS)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .lookupHit (lookupHit),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspWay    (rspWay),
    .rspVictim (rspVictim)
  );

endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic             missClr,
  input logic             rspValid,
  input logic             rspHit,
  input logic [WAY_W-1:0] rspWay,
  input logic [WAY_W-1:0] rspVictim,
  input logic [31:0]      missCount
);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reqValid)) |-> rspValid);

  // R4
  fill_way_is_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspHit) |-> (rspWay == rspVictim));

  // R9
  miss_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspHit && !$past(missClr)) |-> (missCount == $past(missCount) + 32'd1));

  // R9
  hit_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspHit && !$past(missClr)) |-> $stable(missCount));

  // R9
  count_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (missCount == 32'd0));

endmodule

bind repl_tag_directory tagdir_chk #(.WAY_W(WAY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .missClr   (missClr),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspWay    (rspWay),
  .rspVictim (rspVictim),
  .missCount (missCount)
);

// File: tb/tb_repl_tag_directory.sv
module tb_repl_tag_directory;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  policySel = 2'd0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        refClear = 1'b0;
  logic        missClr = 1'b0;
  logic        rspValid;
  logic        rspHit;
  logic [0:0]  rspWay;
  logic [0:0]  rspVictim;
  logic [31:0] missCount;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  repl_tag_directory #(.ADDR_W(32), .LINE_BYTES(32), .WAYS(2), .SETS(128)) dut (
    .clk(clk), .rst(rst), .policySel(policySel), .reqValid(reqValid),
    .reqAddr(reqAddr), .refClear(refClear), .missClr(missClr),
    .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay),
    .rspVictim(rspVictim), .missCount(missCount)
  );

  // {policy[6:5], tagId[4:2], expHit[1], expWay[0]}; all in set 0
  localparam logic [6:0] TRACE [20] = '{
    {2'd0,3'd1,1'b0,1'b0}, {2'd0,3'd2,1'b0,1'b1}, {2'd0,3'd3,1'b0,1'b0},
    {2'd0,3'd1,1'b0,1'b1}, {2'd0,3'd2,1'b0,1'b0}, {2'd0,3'd3,1'b0,1'b1},
    {2'd0,3'd2,1'b1,1'b0}, {2'd0,3'd1,1'b0,1'b0}, {2'd0,3'd2,1'b0,1'b1},
    {2'd0,3'd4,1'b0,1'b0},
    {2'd1,3'd1,1'b0,1'b0}, {2'd1,3'd2,1'b0,1'b1}, {2'd1,3'd3,1'b0,1'b0},
    {2'd1,3'd1,1'b0,1'b1}, {2'd1,3'd2,1'b0,1'b0}, {2'd1,3'd3,1'b0,1'b1},
    {2'd1,3'd2,1'b1,1'b0}, {2'd1,3'd1,1'b0,1'b1}, {2'd1,3'd2,1'b1,1'b0},
    {2'd1,3'd4,1'b0,1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] pol);
    @(negedge clk);
    rst = 1'b1;
    reqValid = 1'b0;
    policySel = pol;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic apply(input logic [31:0] addr, input logic clr);
    @(negedge clk);
    reqAddr = addr;
    reqValid = 1'b1;
    missClr = clr;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    missClr = 1'b0;
  endtask

  task automatic pulseRef();
    @(negedge clk);
    refClear = 1'b1;
    @(negedge clk);
    refClear = 1'b0;
  endtask

  function automatic logic [31:0] tagAddr(input int t);
    return 32'(t) << 12;
  endfunction

  initial begin
    // table walk: R5 FIFO trace, R6 LRU trace
    for (int i = 0; i < 20; i++) begin
      if (i % 10 == 0) doReset(TRACE[i][6:5]);
      apply(tagAddr(int'(TRACE[i][4:2])), 1'b0);
      check(i < 10 ? "R5 hit" : "R6 hit", 32'(rspHit), 32'(TRACE[i][1]));
      check(i < 10 ? "R5 way" : "R6 way", 32'(rspWay), 32'(TRACE[i][0]));
      if (i == 9)  check("R5 miss total", missCount, 32'd9);
      if (i == 19) check("R6 miss total", missCount, 32'd8);
    end

    // reset state: R10, R9
    doReset(2'd0);
    check("R10 rspValid after reset", 32'(rspValid), 32'd0);
    check("R9 count after reset", missCount, 32'd0);
    // R2: zero tag misses after reset; R3 lowest invalid way
    apply(32'h0000_0000, 1'b0);
    check("R10 rspValid", 32'(rspValid), 32'd1);
    check("R2 zero addr misses", 32'(rspHit), 32'd0);
    check("R3 first fill way0", 32'(rspWay), 32'd0);
    // R1: offset ignored, index and tag positions
    apply(32'h0000_001F, 1'b0);
    check("R1 offset ignored hit", 32'(rspHit), 32'd1);
    apply(32'h0000_0020, 1'b0);
    check("R1 set1 miss", 32'(rspHit), 32'd0);
    check("R1 set1 way0", 32'(rspWay), 32'd0);
    apply(32'h0000_1000, 1'b0);
    check("R1 tag bit12 miss", 32'(rspHit), 32'd0);
    check("R3 second fill way1", 32'(rspWay), 32'd1);
    check("R4 victim equals way", 32'(rspVictim), 32'd1);
    apply(32'h0000_1004, 1'b0);
    check("R4 refill hits", 32'(rspHit), 32'd1);
    check("R4 refill way", 32'(rspWay), 32'd1);
    check("R9 count three", missCount, 32'd3);
    // R9 clear, and clear beating a simultaneous miss
    @(negedge clk); missClr = 1'b1;
    @(negedge clk); missClr = 1'b0;
    check("R9 clear", missCount, 32'd0);
    apply(32'h0000_0040, 1'b1);
    check("R9 clear wins over miss", missCount, 32'd0);
    apply(32'h0000_0060, 1'b0);
    check("R9 count after clear", missCount, 32'd1);

    // R7 reference bits
    doReset(2'd2);
    apply(tagAddr(1), 1'b0);
    apply(tagAddr(2), 1'b0);
    apply(tagAddr(3), 1'b0);
    check("R7 all set picks way0", 32'(rspVictim), 32'd0);
    pulseRef();
    apply(tagAddr(2), 1'b0);
    check("R7 hit way1", 32'(rspWay), 32'd1);
    apply(tagAddr(4), 1'b0);
    check("R7 clear bit way0 victim", 32'(rspVictim), 32'd0);
    pulseRef();
    apply(tagAddr(4), 1'b0);
    check("R7 hit way0", 32'(rspHit), 32'd1);
    apply(tagAddr(5), 1'b0);
    check("R7 clear bit way1 victim", 32'(rspVictim), 32'd1);

    // R8 policy change resets order
    doReset(2'd1);
    apply(tagAddr(1), 1'b0);
    apply(tagAddr(2), 1'b0);
    @(negedge clk); policySel = 2'd0;
    repeat (2) @(negedge clk);
    apply(tagAddr(3), 1'b0);
    check("R8 reset order victim", 32'(rspVictim), 32'd1);
    apply(tagAddr(1), 1'b0);
    check("R8 tags kept", 32'(rspHit), 32'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule